// File: doc/BRIEF.md
# Split-Operand Signed Fixed-Point Multiply-Accumulate

This block sums the products of a stream of 32-bit two's-complement fixed-point operand pairs without a full-width signed multiplier. Every operand is cut into two unsigned 16-bit halves. Four unsigned half-width products feed four independent 48-bit lane accumulators. Three sign-correction accumulators run next to the lanes. When a sequence ends, the lanes and corrections are shifted into place and combined modulo 2^80 into one signed sum. A 32-bit window of that sum, placed by the fractional-bit parameter, is the fixed-point result.

A producer presents one operand pair per cycle with `in_valid` high. It marks the first pair of a sequence with `in_start` and the final pair with `in_last`. One clock cycle after the final pair is taken, the block raises `out_done` for one cycle, together with the full 80-bit sum and the windowed fixed-point value. The result bits are taken without rounding or saturation.

Top module: `sfx_mac`

## Requirements
- R1: While reset is high, and after reset is released until the first result, `out_done` is 0, `out_sum` is 0 and `out_fix` is 0.
- R2: `out_sum` equals the sum of the signed products of all operand pairs in the sequence, modulo 2^80. Operands are 32-bit two's complement. The sum is exact for sequences of up to 65536 pairs, and a negative sum appears as its 80-bit two's-complement pattern.
- R3: A pair accepted with `in_start` high discards all earlier accumulation and becomes the first term of a new sum, whether or not the earlier sequence was ended with `in_last`.
- R4: In a cycle with `in_valid` low, the operands, `in_start` and `in_last` have no effect on any later result or strobe.
- R5: `out_done` is high for exactly one cycle. That cycle begins at the second rising edge after the final pair is presented, counting the edge that samples the pair.
- R6: `out_fix` equals bits FRAC+31 down to FRAC of `out_sum`. With the default FRAC = 16 these are bits 47..16. Negative values therefore truncate toward minus infinity.
- R7: `out_sum` and `out_fix` keep their values in every cycle in which `out_done` is low.
- R8: A pair accepted with both `in_start` and `in_last` high forms a one-term sequence. Such sequences may follow each other on every cycle, and each gives its own done strobe.
- R9: A new sequence may start in the cycle right after the final pair of the previous one without altering the previous result.
- R10: Sign correction is exact for every operand value, including 0x80000000. A negative A removes B's unsigned pattern at weight 2^32. A negative B removes A's unsigned pattern at weight 2^32. When both are negative, 2^64 is added back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand pair present this cycle |
| in_start | input | 1 | Pair is the first of a sequence (qualified by in_valid) |
| in_last | input | 1 | Pair is the final one of a sequence (qualified by in_valid) |
| in_a | input | 32 | Operand A, signed fixed point |
| in_b | input | 32 | Operand B, signed fixed point |
| out_done | output | 1 | One-cycle strobe: result registers updated |
| out_sum | output | 80 | Full signed sum of products, modulo 2^80 |
| out_fix | output | 32 | Fixed-point window of out_sum |

## Verification
Two things can happen on the same edge: the combine stage reads the lanes to form a finished result, and the lanes are cleared by the start of the next sequence. The bench provokes this by starting a new sequence on the very cycle after a final pair. It also streams one-term sequences with start and last set on every cycle, so that combining and restarting coincide on consecutive edges. A scoreboard holds each result's reference sum from a 128-bit signed model, plus the cycle in which its strobe is due. It judges every strobe on value and on timing, so a new sequence that leaks into the previous result is caught.

// File: rtl/sfx_mac_pkg.sv
package sfx_mac_pkg;

  // Lane order: bit 0 of the index selects A's high half, bit 1 selects B's high half.
  localparam int NUM_LANES = 4;

  typedef enum logic [1:0] {
    LANE_LOLO = 2'd0,
    LANE_HILO = 2'd1,
    LANE_LOHI = 2'd2,
    LANE_HIHI = 2'd3
  } lane_e;

  // Weight of a lane in the final sum, in bits.
  function automatic int lane_shift(input int idx, input int half_w);
    return half_w * ((idx & 1) + ((idx >> 1) & 1));
  endfunction

endpackage

// File: rtl/sfx_split_mul.sv
module sfx_split_mul
  import sfx_mac_pkg::*;
#(
  parameter int OP_W = 32
) (
  input  logic [OP_W-1:0]                 a,
  input  logic [OP_W-1:0]                 b,
  output logic [NUM_LANES-1:0][OP_W-1:0]  prod
);
  localparam int HALF = OP_W / 2;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    logic [HALF-1:0] ha;
    logic [HALF-1:0] hb;
    assign ha = ((g % 2) == 1)       ? a[OP_W-1:HALF] : a[HALF-1:0];
    assign hb = (((g / 2) % 2) == 1) ? b[OP_W-1:HALF] : b[HALF-1:0];
    assign prod[g] = OP_W'(ha) * OP_W'(hb);
  end

endmodule

// File: rtl/sfx_lane_acc.sv
module sfx_lane_acc #(
  parameter int IN_W  = 32,
  parameter int ACC_W = 48
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             clr,
  input  logic [IN_W-1:0]  din,
  output logic [ACC_W-1:0] acc
);

  always_ff @(posedge clk) begin
    if (rst)
      acc <= '0;
    else if (en)
      acc <= clr ? ACC_W'(din) : acc + ACC_W'(din);
  end

  assert_lane_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(acc));

  assert_lane_restart_R3: assert property (@(posedge clk) disable iff (rst)
    (en && clr) |=> (acc == ACC_W'($past(din))));

endmodule

// File: rtl/sfx_sign_corr.sv
module sfx_sign_corr #(
  parameter int OP_W   = 32,
  parameter int CORR_W = 48,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              clr,
  input  logic [OP_W-1:0]   a,
  input  logic [OP_W-1:0]   b,
  output logic [CORR_W-1:0] da_acc,
  output logic [CORR_W-1:0] db_acc,
  output logic [CNT_W-1:0]  s_cnt
);
  logic neg_a, neg_b;
  logic [CORR_W-1:0] da_add, db_add;
  logic [CNT_W-1:0]  s_add;

  always_comb begin
    neg_a  = a[OP_W-1];
    neg_b  = b[OP_W-1];
    da_add = neg_a ? CORR_W'(b) : '0;
    db_add = neg_b ? CORR_W'(a) : '0;
    s_add  = CNT_W'(neg_a & neg_b);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      da_acc <= '0;
      db_acc <= '0;
      s_cnt  <= '0;
    end else if (en) begin
      da_acc <= clr ? da_add : da_acc + da_add;
      db_acc <= clr ? db_add : db_acc + db_add;
      s_cnt  <= clr ? s_add  : s_cnt + s_add;
    end
  end

  assert_da_idle_R10: assert property (@(posedge clk) disable iff (rst)
    (en && !clr && !a[OP_W-1]) |=> $stable(da_acc));

  assert_both_neg_count_R10: assert property (@(posedge clk) disable iff (rst)
    (en && !clr && !(a[OP_W-1] && b[OP_W-1])) |=> $stable(s_cnt));

  assert_corr_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(db_acc) && $stable(s_cnt)));

endmodule

// File: rtl/sfx_combine.sv
module sfx_combine
  import sfx_mac_pkg::*;
#(
  parameter int OP_W   = 32,
  parameter int LANE_W = 48,
  parameter int FRAC   = 16
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              fire,
  input  logic [NUM_LANES-1:0][LANE_W-1:0]  lanes,
  input  logic [LANE_W-1:0]                 da_acc,
  input  logic [LANE_W-1:0]                 db_acc,
  input  logic [LANE_W-OP_W-1:0]            s_cnt,
  output logic                              out_done,
  output logic [LANE_W+OP_W-1:0]            out_sum,
  output logic [OP_W-1:0]                   out_fix
);
  localparam int HALF  = OP_W / 2;
  localparam int SUM_W = LANE_W + OP_W;

  logic [SUM_W-1:0] total;

  always_comb begin
    total = '0;
    for (int k = 0; k < NUM_LANES; k++)
      total = total + (SUM_W'(lanes[k]) << lane_shift(k, HALF));
    total = total - (SUM_W'(da_acc) << OP_W);
    total = total - (SUM_W'(db_acc) << OP_W);
    total = total + (SUM_W'(s_cnt) << (2 * OP_W));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_done <= 1'b0;
      out_sum  <= '0;
      out_fix  <= '0;
    end else begin
      out_done <= fire;
      if (fire) begin
        out_sum <= total;
        out_fix <= total[FRAC +: OP_W];
      end
    end
  end

  assert_result_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !out_done |-> ($stable(out_sum) && $stable(out_fix)));

endmodule

// File: rtl/sfx_mac.sv
module sfx_mac
  import sfx_mac_pkg::*;
#(
  parameter int OP_W   = 32,
  parameter int LANE_W = 48,
  parameter int FRAC   = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic                   in_start,
  input  logic                   in_last,
  input  logic [OP_W-1:0]        in_a,
  input  logic [OP_W-1:0]        in_b,
  output logic                   out_done,
  output logic [LANE_W+OP_W-1:0] out_sum,
  output logic [OP_W-1:0]        out_fix
);
  localparam int CNT_W = LANE_W - OP_W;

  logic [NUM_LANES-1:0][OP_W-1:0]   prod;
  logic [NUM_LANES-1:0][LANE_W-1:0] lanes;
  logic [LANE_W-1:0]                da_acc, db_acc;
  logic [CNT_W-1:0]                 s_cnt;
  logic                             clr;
  logic                             last_q;

  assign clr = in_start;

  sfx_split_mul #(.OP_W(OP_W)) u_mul (
    .a    (in_a),
    .b    (in_b),
    .prod (prod)
  );

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_acc
    sfx_lane_acc #(.IN_W(OP_W), .ACC_W(LANE_W)) u_lane (
      .clk (clk),
      .rst (rst),
      .en  (in_valid),
      .clr (clr),
      .din (prod[g]),
      .acc (lanes[g])
    );
  end

  sfx_sign_corr #(.OP_W(OP_W), .CORR_W(LANE_W), .CNT_W(CNT_W)) u_corr (
    .clk    (clk),
    .rst    (rst),
    .en     (in_valid),
    .clr    (clr),
    .a      (in_a),
    .b      (in_b),
    .da_acc (da_acc),
    .db_acc (db_acc),
    .s_cnt  (s_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst)
      last_q <= 1'b0;
    else
      last_q <= in_valid & in_last;
  end

  sfx_combine #(.OP_W(OP_W), .LANE_W(LANE_W), .FRAC(FRAC)) u_comb (
    .clk      (clk),
    .rst      (rst),
    .fire     (last_q),
    .lanes    (lanes),
    .da_acc   (da_acc),
    .db_acc   (db_acc),
    .s_cnt    (s_cnt),
    .out_done (out_done),
    .out_sum  (out_sum),
    .out_fix  (out_fix)
  );

  assert_done_follows_last_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_last) |=> ##1 out_done);

  assert_no_spurious_done_R5: assert property (@(posedge clk) disable iff (rst)
    !last_q |=> !out_done);

endmodule

// File: tb/sfx_mac_bench.sv
module sfx_mac_bench;
  localparam int OP_W  = 32;
  localparam int FRAC  = 16;
  localparam int SUM_W = 80;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_start = 1'b0, in_last = 1'b0;
  logic [OP_W-1:0] in_a = '0, in_b = '0;
  logic out_done;
  logic [SUM_W-1:0] out_sum;
  logic [OP_W-1:0] out_fix;

  always #10 clk = ~clk;  // 50 MHz

  sfx_mac #(.OP_W(OP_W), .LANE_W(48), .FRAC(FRAC)) u_sfx_mac (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_start(in_start),
    .in_last(in_last), .in_a(in_a), .in_b(in_b),
    .out_done(out_done), .out_sum(out_sum), .out_fix(out_fix)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  logic signed [127:0] ref_acc = '0;
  logic [SUM_W-1:0] q_sum[$];
  int               q_cyc[$];
  string            q_tag[$];

  task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // Driver: one accepted pair per call; reference model updated here.
  task automatic send(input logic [31:0] a, input logic [31:0] b, input bit st, input bit ls, input string tag);
    logic signed [127:0] p;
    @(negedge clk);
    in_valid = 1'b1; in_a = a; in_b = b; in_start = st; in_last = ls;
    p = $signed({{96{a[31]}}, a}) * $signed({{96{b[31]}}, b});
    if (st) ref_acc = '0;
    ref_acc = ref_acc + p;
    if (ls) begin
      q_sum.push_back(ref_acc[SUM_W-1:0]);
      q_cyc.push_back(cyc + 2);
      q_tag.push_back(tag);
    end
  endtask

  // Idle cycle with junk on every qualified input (R4).
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0; in_start = 1'b1; in_last = 1'b1;
      in_a = $urandom; in_b = $urandom;
    end
  endtask

  task automatic rand_seq(input int n, input bit gaps, input string tag);
    for (int i = 0; i < n; i++) begin
      send($urandom, $urandom, i == 0, i == n - 1, tag);
      if (gaps && (i % 3 == 1)) idle(2);
    end
  endtask

  // Monitor / scoreboard
  logic [SUM_W-1:0] held_sum = '0;
  logic [OP_W-1:0]  held_fix = '0;

  always @(negedge clk) begin
    if (!rst && !finished) begin
      if (out_done) begin
        if (q_sum.size() == 0) begin
          check(1'b0, "R5 unexpected done", 128'(out_done), 128'(0));
        end else begin
          logic [SUM_W-1:0] es;
          int ec;
          string t;
          es = q_sum.pop_front(); ec = q_cyc.pop_front(); t = q_tag.pop_front();
          check(cyc == ec, "R5 done cycle", 128'(cyc), 128'(ec));
          check(out_sum == es, t, 128'(out_sum), 128'(es));
          check(out_fix == es[FRAC +: OP_W], "R6 window", 128'(out_fix), 128'(es[FRAC +: OP_W]));
        end
        held_sum <= out_sum;
        held_fix <= out_fix;
      end else begin
        check(out_sum == held_sum && out_fix == held_fix, "R7 hold", 128'(out_sum), 128'(held_sum));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_done == 1'b0 && out_sum == '0 && out_fix == '0, "R1 reset state",
          128'(out_sum), 128'(0));
    @(negedge clk); rst = 1'b0;
    idle(2);
    check(out_done == 1'b0 && out_sum == '0, "R1 after release", 128'(out_sum), 128'(0));

    // R8: one-term sequence, 3.5 * 2.0
    send(32'h0003_8000, 32'h0002_0000, 1, 1, "R8 single");
    idle(3);
    // R6: -1.5 * 2.0 = -3.0 ; raw 1*1 ; raw -1*1 (floor to all ones)
    send(32'hFFFE_8000, 32'h0002_0000, 1, 1, "R6 negative value");
    idle(2);
    send(32'h0000_0001, 32'h0000_0001, 1, 1, "R6 tiny positive");
    idle(2);
    send(32'hFFFF_FFFF, 32'h0000_0001, 1, 1, "R6 tiny negative");
    idle(3);
    // R2: contiguous random
    rand_seq(16, 0, "R2 random contiguous");
    idle(3);
    // R4: gaps with junk start/last
    rand_seq(10, 1, "R4 gapped sequence");
    idle(3);
    // R10: extreme operands
    send(32'h8000_0000, 32'h8000_0000, 1, 0, "R10 extremes");
    send(32'h8000_0000, 32'h8000_0000, 0, 0, "R10 extremes");
    send(32'h8000_0000, 32'h7FFF_FFFF, 0, 0, "R10 extremes");
    send(32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, "R10 extremes");
    send(32'h7FFF_FFFF, 32'h7FFF_FFFF, 0, 0, "R10 extremes");
    send(32'h8000_0000, 32'h8000_0000, 0, 1, "R10 extremes");
    idle(3);
    send(32'h8000_0000, 32'h8000_0000, 1, 1, "R10 min times min");
    idle(3);
    // R3: abandoned partial sequence, then restart
    send(32'h1234_5678, 32'h8765_4321, 1, 0, "R3 restart");
    send(32'h7FFF_0000, 32'h7FFF_0000, 0, 0, "R3 restart");
    idle(1);
    rand_seq(4, 0, "R3 restart");
    idle(3);
    // R9: back-to-back sequences, then R8 singles every cycle
    rand_seq(5, 0, "R9 first of pair");
    rand_seq(4, 0, "R9 second of pair");
    for (int i = 0; i < 6; i++) send($urandom, $urandom, 1, 1, "R8 R9 singles");
    idle(3);
    // R2: long mixed sequence with extremes
    for (int i = 0; i < 200; i++) begin
      logic [31:0] a, b;
      a = (i % 17 == 0) ? 32'h8000_0000 : $urandom;
      b = (i % 13 == 0) ? 32'h8000_0000 : $urandom;
      send(a, b, i == 0, i == 199, "R2 long mixed");
    end
    idle(5);
    check(q_sum.size() == 0, "R5 all results delivered", 128'(q_sum.size()), 128'(0));
    finish_run();
  end

endmodule